// File: doc/BRIEF.md
# Block Register Transfer Sequencer

This block executes one multi-register load or store. A command carries a 16-bit register mask, a word-aligned base address, a load/store flag, a three-bit mode code and a writeback flag. Once accepted, the sequencer walks the set bits of the mask from bit 0 upward. For each set bit it offers one register number and one word address on a memory port with a valid/ready handshake. After the last word is accepted it pulses `done` for one cycle and presents the updated base value for the register file to write back.

The mode code selects the address pattern. It can be read in two ways. In the block view, the addresses step upward or downward from the base, and the first step is taken either before or after the first word. In the stack view, the stack is ascending or descending and the pointer marks either the last full slot or the next empty one. A stack-view code is turned into a block mode, and the translation differs between loads and stores. In every mode, the lowest-numbered register uses the lowest address. When a load includes the top register (the program counter), a flag is raised with `done` so that the fetch logic can redirect.

Top module: `lsm_sequencer`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `mem_valid` and `done` are 0. `cmd_ready` is 1 only while no command is in progress, and a command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both 1.
- R2: Each set bit of `cmd_mask` produces exactly one accepted memory beat. The beats come in strictly increasing register number, starting with the lowest set bit, and `mem_reg` carries the bit index.
- R3: Beat k (counting from 0, with n set bits and base B) uses address B+4k in increment-after, B+4+4k in increment-before, B−4n+4+4k in decrement-after and B−4n+4k in decrement-before. All addresses are word aligned.
- R4: While `mem_valid` is 1 and `mem_ready` is 0, `mem_valid`, `mem_reg` and `mem_addr` hold their values.
- R5: `mem_write` is 1 for a store (`cmd_load`=0) and 0 for a load during every beat.
- R6: `done` is 1 for exactly one cycle, which is the cycle after the edge that accepts the last beat.
- R7: While `done` is 1, `base_wb_en` equals the writeback flag. With writeback set, `base_wb_value` is B+4n for increasing modes and B−4n for decreasing modes. For example, eight registers in increment-after mode give B+32.
- R8: Mode code bit 2 chooses the view (0 = block, 1 = stack). In the block view, bit 1 is 1 for increasing and bit 0 is 1 for before. In the stack view, bit 1 is 1 for ascending and bit 0 is 1 for full. A stack store uses increasing = ascending and before = full. A stack load uses increasing = not ascending and before = not full. For example, full-descending is decrement-before for a store and increment-after for a load.
- R9: `pc_loaded` is 1 with `done` only when the command was a load and mask bit 15 was set. At all other times it is 0.
- R10: An all-zero mask produces no memory beat. `done` follows in the cycle after acceptance, and `base_wb_value` equals the base.
- R11: `cmd_valid` and the command fields are ignored while a command is in progress. They change neither the beats nor the writeback result of the running command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command can be taken |
| cmd_mask | input | 16 | Register set to transfer |
| cmd_base | input | 32 | Base address, word aligned |
| cmd_load | input | 1 | 1 = load, 0 = store |
| cmd_mode | input | 3 | Addressing mode code (R8) |
| cmd_wb | input | 1 | Write updated base back |
| mem_valid | output | 1 | Beat offered to memory |
| mem_ready | input | 1 | Memory takes the beat |
| mem_reg | output | 4 | Register number of the beat |
| mem_addr | output | 32 | Word address of the beat |
| mem_write | output | 1 | Beat is a store |
| done | output | 1 | One-cycle completion pulse |
| base_wb_en | output | 1 | Base writeback strobe |
| base_wb_value | output | 32 | Updated base value |
| pc_loaded | output | 1 | Load included the program counter |

## Verification
The hardest situation to reach is a long transfer whose address window lies below the base, such as a full 16-register decrement-before store, while the memory stalls irregularly and new commands are presented in the middle of it. The bench drives `mem_ready` from a pseudo-random sequence during such transfers, so the hold behaviour is exercised in every address mode. During a stalled 16-beat transfer it also keeps `cmd_valid` high with a different mask for several cycles. A behavioural queue model, compared on every cycle, then shows that both the beat stream and the writeback value belong to the original command.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
    localparam int MODE_W         = 3;
    localparam int MODE_STACK_BIT = 2;
    localparam int MODE_UP_BIT    = 1;
    localparam int MODE_PRE_BIT   = 0;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_XFER = 2'd1,
        SEQ_FIN  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/lsm_mode_map.sv
module lsm_mode_map
    import lsm_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic              is_load,
    output logic              step_up,
    output logic              step_pre
);
    // Stack view: a store keeps the direction and fullness bits as they are,
    // and a load inverts both of them.
    logic flip;

    always_comb begin
        flip     = mode[MODE_STACK_BIT] & is_load;
        step_up  = mode[MODE_UP_BIT] ^ flip;
        step_pre = mode[MODE_PRE_BIT] ^ flip;
    end
endmodule

// File: rtl/lsm_lowest.sv
module lsm_lowest #(
    parameter int N = 16,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     bits,
    output logic [N-1:0]     first_hot,
    output logic [IDX_W-1:0] first_idx
);
    logic [N:0] seen;
    assign seen[0] = 1'b0;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_chain
            assign first_hot[g] = bits[g] & ~seen[g];
            assign seen[g+1]    = seen[g] | bits[g];
        end
    endgenerate

    always_comb begin
        first_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (first_hot[i]) first_idx = first_idx | IDX_W'(i);
        end
    end
endmodule

// File: rtl/lsm_addr_plan.sv
module lsm_addr_plan #(
    parameter int N      = 16,
    parameter int ADDR_W = 32,
    localparam int CNT_W = $clog2(N + 1)
) (
    input  logic [N-1:0]      mask,
    input  logic [ADDR_W-1:0] base,
    input  logic              step_up,
    input  logic              step_pre,
    input  logic              wb,
    output logic [ADDR_W-1:0] first_addr,
    output logic [ADDR_W-1:0] new_base
);
    localparam logic [ADDR_W-1:0] WORD = ADDR_W'(4);

    logic [CNT_W-1:0]  count;
    logic [ADDR_W-1:0] span;

    always_comb begin
        count = '0;
        for (int i = 0; i < N; i++) count = count + CNT_W'(mask[i]);
        span = ADDR_W'(count) << 2;

        if (step_up) first_addr = step_pre ? base + WORD : base;
        else         first_addr = step_pre ? base - span : base - span + WORD;

        if (!wb)          new_base = base;
        else if (step_up) new_base = base + span;
        else              new_base = base - span;
    end
endmodule

// File: rtl/lsm_sequencer.sv
module lsm_sequencer
    import lsm_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int ADDR_W   = 32,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic [NUM_REGS-1:0] cmd_mask,
    input  logic [ADDR_W-1:0]   cmd_base,
    input  logic                cmd_load,
    input  logic [MODE_W-1:0]   cmd_mode,
    input  logic                cmd_wb,
    output logic                mem_valid,
    input  logic                mem_ready,
    output logic [IDX_W-1:0]    mem_reg,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                mem_write,
    output logic                done,
    output logic                base_wb_en,
    output logic [ADDR_W-1:0]   base_wb_value,
    output logic                pc_loaded
);
    localparam logic [ADDR_W-1:0] WORD = ADDR_W'(4);

    typedef struct packed {
        seq_state_e          state;
        logic [NUM_REGS-1:0] left;
        logic [ADDR_W-1:0]   addr;
        logic [ADDR_W-1:0]   fin_base;
        logic                load;
        logic                pc_hit;
        logic                wb;
    } seq_t;

    seq_t seq_d, seq_q;

    logic                step_up, step_pre;
    logic [ADDR_W-1:0]   plan_first, plan_base;
    logic [NUM_REGS-1:0] pick_hot;
    logic [IDX_W-1:0]    pick_idx;
    logic [NUM_REGS-1:0] left_after;

    lsm_mode_map u_mode (
        .mode     (cmd_mode),
        .is_load  (cmd_load),
        .step_up  (step_up),
        .step_pre (step_pre)
    );

    lsm_addr_plan #(.N(NUM_REGS), .ADDR_W(ADDR_W)) u_plan (
        .mask       (cmd_mask),
        .base       (cmd_base),
        .step_up    (step_up),
        .step_pre   (step_pre),
        .wb         (cmd_wb),
        .first_addr (plan_first),
        .new_base   (plan_base)
    );

    lsm_lowest #(.N(NUM_REGS)) u_pick (
        .bits      (seq_q.left),
        .first_hot (pick_hot),
        .first_idx (pick_idx)
    );

    always_comb begin
        seq_d      = seq_q;
        left_after = seq_q.left & ~pick_hot;
        case (seq_q.state)
            SEQ_IDLE: begin
                if (cmd_valid) begin
                    seq_d.left     = cmd_mask;
                    seq_d.addr     = plan_first;
                    seq_d.fin_base = plan_base;
                    seq_d.load     = cmd_load;
                    seq_d.pc_hit   = cmd_load & cmd_mask[NUM_REGS-1];
                    seq_d.wb       = cmd_wb;
                    seq_d.state    = (|cmd_mask) ? SEQ_XFER : SEQ_FIN;
                end
            end
            SEQ_XFER: begin
                if (mem_ready) begin
                    seq_d.left = left_after;
                    seq_d.addr = seq_q.addr + WORD;
                    if (left_after == '0) seq_d.state = SEQ_FIN;
                end
            end
            SEQ_FIN:  seq_d.state = SEQ_IDLE;
            default:  seq_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        cmd_ready     = (seq_q.state == SEQ_IDLE);
        mem_valid     = (seq_q.state == SEQ_XFER);
        mem_reg       = pick_idx;
        mem_addr      = seq_q.addr;
        mem_write     = ~seq_q.load;
        done          = (seq_q.state == SEQ_FIN);
        base_wb_en    = done & seq_q.wb;
        base_wb_value = seq_q.fin_base;
        pc_loaded     = done & seq_q.pc_hit;
    end

    // R1: an idle sequencer drives no beat and no completion
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!mem_valid && !done));

    // R2: register numbers rise from one beat to the next
    assert_reg_rising_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready) |=> (!mem_valid || (mem_reg > $past(mem_reg))));

    // R3: consecutive beats use consecutive word addresses
    assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready) |=> (!mem_valid || (mem_addr == $past(mem_addr) + WORD)));

    assert_addr_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_addr[1:0] == 2'b00));

    // R4: a stalled beat holds still
    assert_stall_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_reg)));

    // R6: completion is a single-cycle pulse with no beat beside it
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_alone_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_valid);

    // R9: the program-counter flag comes only with the completion of a load
    assert_pc_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pc_loaded |-> (done && !mem_write));

    // R11: no new command is taken while a beat is pending
    assert_busy_closed_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !cmd_ready);
endmodule

// File: tb/test_lsm_sequencer.sv
module test_lsm_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [15:0] cmd_mask = '0;
    logic [31:0] cmd_base = '0;
    logic        cmd_load = 1'b0;
    logic [2:0]  cmd_mode = '0;
    logic        cmd_wb = 1'b0;
    logic        mem_valid;
    logic        mem_ready = 1'b1;
    logic [3:0]  mem_reg;
    logic [31:0] mem_addr;
    logic        mem_write;
    logic        done;
    logic        base_wb_en;
    logic [31:0] base_wb_value;
    logic        pc_loaded;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;   // 125 MHz

    lsm_sequencer i_lsm_sequencer (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_mask(cmd_mask), .cmd_base(cmd_base), .cmd_load(cmd_load),
        .cmd_mode(cmd_mode), .cmd_wb(cmd_wb),
        .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_reg(mem_reg), .mem_addr(mem_addr), .mem_write(mem_write),
        .done(done), .base_wb_en(base_wb_en), .base_wb_value(base_wb_value),
        .pc_loaded(pc_loaded)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int          m_state = 0;          // 0 idle, 1 transferring, 2 finishing
    int          q_reg[$];
    logic [31:0] q_addr[$];
    bit          m_load, m_wb, m_pc;
    logic [31:0] m_final;
    int          beats = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0;
            q_reg.delete();
            q_addr.delete();
        end else begin
            case (m_state)
                0: if (cmd_valid) begin
                    int n, k;
                    bit up, pre;
                    n = $countones(cmd_mask);
                    if (cmd_mode[2]) begin
                        up  = cmd_load ? !cmd_mode[1] : cmd_mode[1];
                        pre = cmd_load ? !cmd_mode[0] : cmd_mode[0];
                    end else begin
                        up  = cmd_mode[1];
                        pre = cmd_mode[0];
                    end
                    k = 0;
                    for (int r = 0; r < 16; r++) begin
                        if (cmd_mask[r]) begin
                            q_reg.push_back(r);
                            if (up) q_addr.push_back(pre ? cmd_base + 4*(k+1) : cmd_base + 4*k);
                            else    q_addr.push_back(pre ? cmd_base - 4*n + 4*k : cmd_base - 4*n + 4 + 4*k);
                            k++;
                        end
                    end
                    m_load  = cmd_load;
                    m_wb    = cmd_wb;
                    m_pc    = cmd_load && cmd_mask[15];
                    m_final = up ? cmd_base + 4*n : cmd_base - 4*n;
                    if (!cmd_wb) m_final = cmd_base;
                    m_state = (n == 0) ? 2 : 1;
                end
                1: if (mem_ready) begin
                    void'(q_reg.pop_front());
                    void'(q_addr.pop_front());
                    beats++;
                    if (q_reg.size() == 0) m_state = 2;
                end
                default: m_state = 0;
            endcase
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(cmd_ready == (m_state == 0), "R1 cmd_ready", 32'(cmd_ready), 32'(m_state == 0));
            chk(mem_valid == (m_state == 1), "R2 mem_valid", 32'(mem_valid), 32'(m_state == 1));
            if (m_state == 1 && mem_valid) begin
                chk(mem_reg == q_reg[0], "R2 mem_reg", 32'(mem_reg), 32'(q_reg[0]));
                chk(mem_addr == q_addr[0], "R3 mem_addr", mem_addr, q_addr[0]);
                chk(mem_write == !m_load, "R5 mem_write", 32'(mem_write), 32'(!m_load));
            end
            chk(done == (m_state == 2), "R6 done", 32'(done), 32'(m_state == 2));
            if (m_state == 2) begin
                chk(base_wb_en == m_wb, "R7 base_wb_en", 32'(base_wb_en), 32'(m_wb));
                if (m_wb) chk(base_wb_value == m_final, "R7 base_wb_value", base_wb_value, m_final);
                chk(pc_loaded == m_pc, "R9 pc_loaded", 32'(pc_loaded), 32'(m_pc));
            end else begin
                chk(pc_loaded == 1'b0, "R9 pc_loaded idle", 32'(pc_loaded), 32'd0);
            end
        end
    end

    // Memory stall pattern (R4)
    bit        stall_en = 1'b0;
    logic [7:0] lfsr = 8'hA5;
    always @(negedge clk) begin
        lfsr      <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        mem_ready <= stall_en ? lfsr[0] : 1'b1;
    end

    logic [31:0] got_wb;
    logic        got_wben, got_pc;

    task automatic run_cmd(input logic [15:0] mask, input logic [31:0] base, input bit load,
                           input logic [2:0] mode, input bit wb, input bit poke_busy);
        while (!(cmd_ready && m_state == 0)) @(negedge clk);
        beats = 0;
        cmd_mask  <= mask;
        cmd_base  <= base;
        cmd_load  <= load;
        cmd_mode  <= mode;
        cmd_wb    <= wb;
        cmd_valid <= 1'b1;
        @(negedge clk);
        if (poke_busy) begin
            // R11: a different command offered while busy
            cmd_mask <= 16'h00F0;
            cmd_base <= 32'h0000_9000;
            cmd_mode <= 3'b011;
            cmd_load <= !load;
            repeat (3) @(negedge clk);
        end
        cmd_valid <= 1'b0;
        while (!done) @(negedge clk);
        got_wb   = base_wb_value;
        got_wben = base_wb_en;
        got_pc   = pc_loaded;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired (R6 completion never seen)");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n <= 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(cmd_ready === 1'b1, "R1 reset cmd_ready", 32'(cmd_ready), 32'd1);
        chk(mem_valid === 1'b0, "R1 reset mem_valid", 32'(mem_valid), 32'd0);
        chk(done === 1'b0, "R1 reset done", 32'(done), 32'd0);

        // R7 R2: eight registers, increment-after load, base moves by 32
        run_cmd(16'h03FC, 32'h0000_1000, 1'b1, 3'b010, 1'b1, 1'b0);
        chk(got_wb == 32'h0000_1020, "R7 IA eight words", got_wb, 32'h0000_1020);
        chk(beats == 8, "R2 beat count", 32'(beats), 32'd8);

        // R3 R9: increment-before store touching r15, no pc flag for stores
        run_cmd(16'h8001, 32'h0000_2000, 1'b0, 3'b011, 1'b1, 1'b0);
        chk(got_wb == 32'h0000_2008, "R3 IB new base", got_wb, 32'h0000_2008);
        chk(got_pc == 1'b0, "R9 store with r15", 32'(got_pc), 32'd0);

        // R9: decrement-after load including r15
        run_cmd(16'h8421, 32'h0000_3000, 1'b1, 3'b000, 1'b1, 1'b0);
        chk(got_wb == 32'h0000_2FF0, "R3 DA new base", got_wb, 32'h0000_2FF0);
        chk(got_pc == 1'b1, "R9 load with r15", 32'(got_pc), 32'd1);

        // R4: all sixteen, decrement-before store, with memory stalls
        stall_en = 1'b1;
        run_cmd(16'hFFFF, 32'h0000_4000, 1'b0, 3'b001, 1'b1, 1'b0);
        chk(got_wb == 32'h0000_3FC0, "R4 DB stalled new base", got_wb, 32'h0000_3FC0);
        chk(beats == 16, "R4 stalled beat count", 32'(beats), 32'd16);

        // R7: writeback clear
        run_cmd(16'h0F00, 32'h0000_5000, 1'b1, 3'b010, 1'b0, 1'b0);
        chk(got_wben == 1'b0, "R7 writeback clear", 32'(got_wben), 32'd0);

        // R10: empty mask
        run_cmd(16'h0000, 32'h0000_6000, 1'b1, 3'b011, 1'b1, 1'b0);
        chk(beats == 0, "R10 no beats", 32'(beats), 32'd0);
        chk(got_wb == 32'h0000_6000, "R10 base kept", got_wb, 32'h0000_6000);

        // R8: stack views (full-descending store / load, empty-ascending load)
        run_cmd(16'h4006, 32'h0000_7000, 1'b0, 3'b101, 1'b1, 1'b0);
        chk(got_wb == 32'h0000_6FF4, "R8 FD store as DB", got_wb, 32'h0000_6FF4);
        run_cmd(16'h4006, 32'h0000_6FF4, 1'b1, 3'b101, 1'b1, 1'b0);
        chk(got_wb == 32'h0000_7000, "R8 FD load as IA", got_wb, 32'h0000_7000);
        run_cmd(16'h0013, 32'h0000_8000, 1'b1, 3'b110, 1'b1, 1'b0);
        chk(got_wb == 32'h0000_7FF4, "R8 EA load as DB", got_wb, 32'h0000_7FF4);
        run_cmd(16'h0013, 32'h0000_8000, 1'b0, 3'b100, 1'b1, 1'b0);
        chk(got_wb == 32'h0000_7FF4, "R8 ED store as DA", got_wb, 32'h0000_7FF4);

        // R11: command offered while busy is ignored
        run_cmd(16'hFFFF, 32'h0000_A000, 1'b1, 3'b010, 1'b1, 1'b1);
        chk(beats == 16, "R11 beats of first command", 32'(beats), 32'd16);
        chk(got_wb == 32'h0000_A040, "R11 base of first command", got_wb, 32'h0000_A040);
        chk(got_pc == 1'b1, "R11 pc flag of first command", 32'(got_pc), 32'd1);
        stall_en = 1'b0;

        repeat (4) @(negedge clk);
        chk(cmd_ready == 1'b1, "R11 idle after busy poke", 32'(cmd_ready), 32'd1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule